// File: doc/BRIEF.md
# Character LCD Scan Timing Generator

This block produces the multiplexed drive timing for a character dot-matrix LCD panel. It runs on the oscillator clock. Each row period it walks a common counter through the rows of the active duty. For the row that will be shown next, it fetches the font row of every character cell through a row-address/data port. The dots are pushed one per clock into a segment shift register and, at the end of the period, copied in parallel into a segment latch. The next common line turns on at the same moment. The newly latched row is then displayed while the following row is fetched.

Dots past the last on-chip segment spill out of the shift register onto a serial extension port, together with a shift clock. A latch pulse for cascaded column drivers accompanies every row change, and a polarity-alternation output keeps the panel drive free of DC. The duty, set by the line-count and font-height inputs, also sets the length of the row period. A change of mode waits for the end of the current frame. The block also draws the cursor underline and the blinking cursor cell, and blanks the segment outputs when the display is switched off.

Top module: `lcd_scan_timing`

## Requirements
- R1: `com_out` is all zero or one-hot. Frame after frame it steps through rows 0 to rows-1 and then wraps. The number of rows comes from the mode: `two_line`=1 gives 16 rows, `two_line`=0 with `tall_font`=0 gives 8 rows, and `two_line`=0 with `tall_font`=1 gives 11 rows.
- R2: A row period lasts ROW_SHORT clocks at 16 rows and ROW_LONG clocks at 8 or 11 rows.
- R3: When `ext_latch` is high, `seg_out[d]` holds dot d of the row that `com_out` has just selected. The block takes dot d from character cell c=d/CHAR_W and column k=d%CHAR_W, which reads bit `font_bits[CHAR_W-1-k]`. It presents that cell as `font_pos` = line*T/CHAR_W + c, where T = NSEG+EXT_DOTS. It presents the row within the cell as `font_row`. At 16 rows the line is row/8 and the row within the cell is row%8; at 8 or 11 rows the line is 0 and the row within the cell is the row itself. The font memory answers one clock after the address.
- R4: Between two `ext_latch` pulses, `ext_sclk` pulses exactly T times. The last EXT_DOTS bits it clocks out, in order, are dots T-1 down to NSEG.
- R5: `alt_out` changes only in a cycle where `ext_latch` is high. With `alt_per_row`=1 it toggles at every row change. With `alt_per_row`=0 it toggles only when row 0 is selected.
- R6: While `disp_en` is 0, `seg_out` is zero from the next clock on, and the latched row is kept. Raising `disp_en` again restores the latched row.
- R7: `frame_start` is a one-cycle pulse that comes with `ext_latch` whenever row 0 is selected. A mode change made in the middle of a frame takes effect from the next frame on.
- R8: With `cur_en`=1, the cell whose `font_pos` equals `cur_pos` shows all dots on in its bottom font row. The bottom row is row 10 at 11 rows and row 7 otherwise.
- R9: With `blink_en`=1, the cursor cell is all on in every row during frames in which (frame index / BLINK_FRAMES) is odd. Frames are counted from 0 after reset.
- R10: After reset, `com_out`, `seg_out`, `alt_out`, `ext_latch` and `frame_start` are 0, and the first frame uses 16 rows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| two_line | input | 1 | 1 = two text lines (16 rows) |
| tall_font | input | 1 | 1 = tall font (11 rows) when single line |
| disp_en | input | 1 | Display enable; 0 blanks the segments |
| cur_en | input | 1 | Cursor underline enable |
| blink_en | input | 1 | Cursor cell blink enable |
| cur_pos | input | POS_W | Cursor cell index, same numbering as font_pos |
| alt_per_row | input | 1 | 1 = alternate per row, 0 = per frame |
| font_pos | output | POS_W | Character cell being fetched |
| font_row | output | 4 | Row inside the character cell |
| font_bits | input | CHAR_W | Font row data, one clock after the address |
| seg_out | output | NSEG | Latched segment data |
| com_out | output | 16 | One-hot common select |
| frame_start | output | 1 | Pulse when row 0 is selected |
| ext_sclk | output | 1 | Extension shift clock pulse |
| ext_latch | output | 1 | Extension latch pulse, with each row change |
| ext_data | output | 1 | Extension serial dot data |
| alt_out | output | 1 | Drive polarity alternation |

## Verification
On every cycle, the assertions check that the common select stays one-hot, that the row index stays below the duty, and that each row period holds exactly T shift pulses. They also check that the frame strobe lines up with row 0, that the polarity flips only at row changes (and at every row change in per-row mode), that blanking follows the enable, and that the duty never changes inside a frame. Only the bench scenarios can show that the right font dots land on the right segments and extension bits, including the cursor underline and the blinking cell. The same holds for the row lengths in each mode, and for a mid-frame mode change holding off until the next frame.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  localparam int COMS = 16;

  typedef enum logic [1:0] {
    DUTY_8  = 2'd0,
    DUTY_11 = 2'd1,
    DUTY_16 = 2'd2
  } duty_e;

  function automatic logic [4:0] duty_rows(input duty_e d);
    case (d)
      DUTY_8:  return 5'd8;
      DUTY_11: return 5'd11;
      default: return 5'd16;
    endcase
  endfunction

  function automatic duty_e duty_pick(input logic two_line, input logic tall_font);
    if (two_line) return DUTY_16;
    if (tall_font) return DUTY_11;
    return DUTY_8;
  endfunction
endpackage

// File: rtl/lcd_row_timer.sv
module lcd_row_timer
  import lcd_scan_pkg::*;
#(
  parameter int ROW_LONG     = 400,
  parameter int ROW_SHORT    = 200,
  parameter int BLINK_FRAMES = 32,
  parameter int CNT_W        = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             two_line,
  input  logic             tall_font,
  output logic [CNT_W-1:0] cnt,
  output logic [3:0]       frow,
  output duty_e            duty_act,
  output logic             blink_phase,
  output logic             row_end
);
  localparam int FW = $clog2(BLINK_FRAMES + 1);

  logic [CNT_W-1:0] period_m1;
  logic             last_row;
  logic [FW-1:0]    fcnt;

  always_comb begin
    period_m1 = (duty_act == DUTY_16) ? CNT_W'(ROW_SHORT - 1) : CNT_W'(ROW_LONG - 1);
    row_end   = (cnt == period_m1);
    last_row  = ({1'b0, frow} == duty_rows(duty_act) - 5'd1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt         <= '0;
      frow        <= '0;
      duty_act    <= DUTY_16;
      fcnt        <= '0;
      blink_phase <= 1'b0;
    end else if (row_end) begin
      cnt <= '0;
      if (last_row) begin
        frow     <= '0;
        duty_act <= duty_pick(two_line, tall_font);
        if (fcnt == FW'(BLINK_FRAMES - 1)) begin
          fcnt        <= '0;
          blink_phase <= ~blink_phase;
        end else begin
          fcnt <= fcnt + FW'(1);
        end
      end else begin
        frow <= frow + 4'd1;
      end
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  a_r1_row_below_duty: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, frow} < duty_rows(duty_act)));
  a_r2_cnt_in_period: assert property (@(posedge clk) disable iff (rst)
    (cnt <= period_m1));
  a_r7_duty_holds_in_frame: assert property (@(posedge clk) disable iff (rst)
    !(row_end && last_row) |=> $stable(duty_act));
endmodule

// File: rtl/lcd_dot_fetch.sv
module lcd_dot_fetch
  import lcd_scan_pkg::*;
#(
  parameter int NSEG     = 40,
  parameter int EXT_DOTS = 40,
  parameter int CHAR_W   = 5,
  parameter int POS_W    = 5,
  parameter int CNT_W    = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [3:0]        frow,
  input  duty_e             duty_act,
  input  logic              blink_phase,
  input  logic              cur_en,
  input  logic              blink_en,
  input  logic [POS_W-1:0]  cur_pos,
  output logic [POS_W-1:0]  font_pos,
  output logic [3:0]        font_row,
  input  logic [CHAR_W-1:0] font_bits,
  output logic [NSEG-1:0]   sr,
  output logic              ext_sclk,
  output logic              ext_data
);
  localparam int TOTAL = NSEG + EXT_DOTS;
  localparam int TCH   = TOTAL / CHAR_W;
  localparam int COLW  = (CHAR_W > 1) ? $clog2(CHAR_W) : 1;

  int   dot_i, chr_i, col_i, rin_i, pos_i, bot_i;
  logic two, fire, force_c, pick;
  logic v1, v2, f1, f2;
  logic [COLW-1:0] col1, col2;

  always_comb begin
    dot_i   = TOTAL - 1 - int'(cnt);
    chr_i   = dot_i / CHAR_W;
    col_i   = dot_i % CHAR_W;
    two     = (duty_act == DUTY_16);
    rin_i   = two ? int'(frow[2:0]) : int'(frow);
    pos_i   = (two && frow[3]) ? chr_i + TCH : chr_i;
    bot_i   = (duty_act == DUTY_11) ? 10 : 7;
    fire    = int'(cnt) < TOTAL;
    force_c = (pos_i == int'(cur_pos)) &&
              ((blink_en && blink_phase) || (cur_en && rin_i == bot_i));
    pick    = font_bits[CHAR_W - 1 - int'(col2)];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0; v2 <= 1'b0; f1 <= 1'b0; f2 <= 1'b0;
      col1 <= '0; col2 <= '0;
      font_pos <= '0; font_row <= '0;
      sr <= '0; ext_sclk <= 1'b0; ext_data <= 1'b0;
    end else begin
      v1 <= fire;
      if (fire) begin
        font_pos <= POS_W'(pos_i);
        font_row <= 4'(rin_i);
        col1     <= COLW'(col_i);
        f1       <= force_c;
      end
      v2       <= v1;
      col2     <= col1;
      f2       <= f1;
      ext_sclk <= v2;
      if (v2) begin
        sr       <= {sr[NSEG-2:0], f2 | pick};
        ext_data <= sr[NSEG-1];
      end
    end
  end

  a_r3_fetch_pipe_clean: assert property (@(posedge clk) disable iff (rst)
    ext_sclk |-> !fire || int'(cnt) >= 2);
endmodule

// File: rtl/lcd_seg_drive.sv
module lcd_seg_drive
  import lcd_scan_pkg::*;
#(
  parameter int NSEG = 40
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            row_end,
  input  logic [3:0]      frow,
  input  logic [NSEG-1:0] sr,
  input  logic            disp_en,
  input  logic            alt_per_row,
  output logic [NSEG-1:0] seg_out,
  output logic [COMS-1:0] com_out,
  output logic            ext_latch,
  output logic            frame_start,
  output logic            alt_out
);
  logic [NSEG-1:0] hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold <= '0; seg_out <= '0; com_out <= '0;
      ext_latch <= 1'b0; frame_start <= 1'b0; alt_out <= 1'b0;
    end else if (row_end) begin
      hold        <= sr;
      seg_out     <= disp_en ? sr : '0;
      com_out     <= COMS'(1) << frow;
      ext_latch   <= 1'b1;
      frame_start <= (frow == 4'd0);
      if (alt_per_row || frow == 4'd0) alt_out <= ~alt_out;
    end else begin
      seg_out     <= disp_en ? hold : '0;
      ext_latch   <= 1'b0;
      frame_start <= 1'b0;
    end
  end

  a_r1_com_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(com_out));
  a_r1_com_steady: assert property (@(posedge clk) disable iff (rst)
    !ext_latch |-> $stable(com_out));
  a_r7_strobe_at_row0: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (ext_latch && com_out[0]));
  a_r5_alt_at_row_change: assert property (@(posedge clk) disable iff (rst)
    !$stable(alt_out) |-> ext_latch);
  a_r5_alt_per_row: assert property (@(posedge clk) disable iff (rst)
    (ext_latch && $past(alt_per_row)) |-> (alt_out != $past(alt_out)));
  a_r6_blank_when_off: assert property (@(posedge clk) disable iff (rst)
    !$past(disp_en) |-> (seg_out == '0));
endmodule

// File: rtl/lcd_scan_timing.sv
module lcd_scan_timing
  import lcd_scan_pkg::*;
#(
  parameter int NSEG         = 40,
  parameter int EXT_DOTS     = 40,
  parameter int CHAR_W       = 5,
  parameter int ROW_LONG     = 400,
  parameter int ROW_SHORT    = 200,
  parameter int BLINK_FRAMES = 32,
  localparam int TOTAL = NSEG + EXT_DOTS,
  localparam int POS_W = $clog2(2 * (TOTAL / CHAR_W)),
  localparam int CNT_W = $clog2(((ROW_LONG > ROW_SHORT) ? ROW_LONG : ROW_SHORT) + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              two_line,
  input  logic              tall_font,
  input  logic              disp_en,
  input  logic              cur_en,
  input  logic              blink_en,
  input  logic [POS_W-1:0]  cur_pos,
  input  logic              alt_per_row,
  output logic [POS_W-1:0]  font_pos,
  output logic [3:0]        font_row,
  input  logic [CHAR_W-1:0] font_bits,
  output logic [NSEG-1:0]   seg_out,
  output logic [15:0]       com_out,
  output logic              frame_start,
  output logic              ext_sclk,
  output logic              ext_latch,
  output logic              ext_data,
  output logic              alt_out
);
  localparam int SCW = $clog2(TOTAL + 1);

  logic [CNT_W-1:0] cnt;
  logic [3:0]       frow;
  duty_e            duty_act;
  logic             blink_phase, row_end;
  logic [NSEG-1:0]  sr;

  lcd_row_timer #(
    .ROW_LONG(ROW_LONG), .ROW_SHORT(ROW_SHORT),
    .BLINK_FRAMES(BLINK_FRAMES), .CNT_W(CNT_W)
  ) u_timer (
    .clk(clk), .rst(rst), .two_line(two_line), .tall_font(tall_font),
    .cnt(cnt), .frow(frow), .duty_act(duty_act),
    .blink_phase(blink_phase), .row_end(row_end)
  );

  lcd_dot_fetch #(
    .NSEG(NSEG), .EXT_DOTS(EXT_DOTS), .CHAR_W(CHAR_W),
    .POS_W(POS_W), .CNT_W(CNT_W)
  ) u_fetch (
    .clk(clk), .rst(rst), .cnt(cnt), .frow(frow), .duty_act(duty_act),
    .blink_phase(blink_phase), .cur_en(cur_en), .blink_en(blink_en),
    .cur_pos(cur_pos), .font_pos(font_pos), .font_row(font_row),
    .font_bits(font_bits), .sr(sr), .ext_sclk(ext_sclk), .ext_data(ext_data)
  );

  lcd_seg_drive #(.NSEG(NSEG)) u_drive (
    .clk(clk), .rst(rst), .row_end(row_end), .frow(frow), .sr(sr),
    .disp_en(disp_en), .alt_per_row(alt_per_row), .seg_out(seg_out),
    .com_out(com_out), .ext_latch(ext_latch), .frame_start(frame_start),
    .alt_out(alt_out)
  );

  // Checker state: shift pulses seen since the previous row change.
  logic [SCW-1:0] sclk_seen;
  always_ff @(posedge clk) begin
    if (rst) sclk_seen <= '0;
    else if (ext_latch) sclk_seen <= SCW'(ext_sclk);
    else sclk_seen <= sclk_seen + SCW'(ext_sclk);
  end

  a_r4_shift_count: assert property (@(posedge clk) disable iff (rst)
    ext_latch |-> (sclk_seen == SCW'(TOTAL)));
  a_r4_no_shift_at_latch: assert property (@(posedge clk) disable iff (rst)
    ext_latch |-> !ext_sclk);
endmodule

// File: tb/lcd_scan_timing_tb.sv
module lcd_scan_timing_tb;
  localparam int CLK_P = 10;
  localparam int NSEG = 10, EXT = 5, CW = 5, RL = 24, RS = 20, BF = 2;
  localparam int TOTAL = NSEG + EXT;
  localparam int TCH = TOTAL / CW;
  localparam int POS_W = $clog2(2 * TCH);

  logic clk = 1'b0, rst = 1'b1;
  logic two_line = 1'b1, tall_font = 1'b0, disp_en = 1'b1;
  logic cur_en = 1'b0, blink_en = 1'b0, alt_per_row = 1'b1;
  logic [POS_W-1:0] cur_pos = '0, font_pos;
  logic [3:0] font_row;
  logic [CW-1:0] font_bits = '0;
  logic [NSEG-1:0] seg_out;
  logic [15:0] com_out;
  logic frame_start, ext_sclk, ext_latch, ext_data, alt_out;

  int n_chk = 0, n_bad = 0;
  logic done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  lcd_scan_timing #(.NSEG(NSEG), .EXT_DOTS(EXT), .CHAR_W(CW), .ROW_LONG(RL),
    .ROW_SHORT(RS), .BLINK_FRAMES(BF)) u_dut (
    .clk(clk), .rst(rst), .two_line(two_line), .tall_font(tall_font),
    .disp_en(disp_en), .cur_en(cur_en), .blink_en(blink_en), .cur_pos(cur_pos),
    .alt_per_row(alt_per_row), .font_pos(font_pos), .font_row(font_row),
    .font_bits(font_bits), .seg_out(seg_out), .com_out(com_out),
    .frame_start(frame_start), .ext_sclk(ext_sclk), .ext_latch(ext_latch),
    .ext_data(ext_data), .alt_out(alt_out));

  function automatic logic [CW-1:0] fb(input int p, input int r);
    return CW'((p * 11 + r * 5 + 6) ^ (r * 4));
  endfunction

  always_ff @(posedge clk) font_bits <= fb(int'(font_pos), int'(font_row));

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model state
  int fduty = 16, erow = 0, frm = 0, gap = 0;
  logic first = 1'b1, ealt = 1'b0;
  logic [NSEG-1:0] ehold = '0;
  logic [EXT-1:0] er = '0;
  int snap_cp = 0;
  logic snap_ce = 1'b0, snap_be = 1'b0;

  always @(negedge clk) begin
    if (!rst && !done) begin
      gap++;
      if (ext_sclk) begin
        er = {er[EXT-2:0], ext_data};
        snap_cp = int'(cur_pos); snap_ce = cur_en; snap_be = blink_en;
      end
      if (ext_latch) begin
        logic [NSEG-1:0] eseg;
        logic [EXT-1:0] eext;
        logic by_cur, by_blink;
        string tag;
        by_cur = 1'b0; by_blink = 1'b0;
        for (int d = 0; d < TOTAL; d++) begin
          int chr, col, rin, pos, bot;
          logic b, fc, fbk;
          chr = d / CW; col = d % CW;
          rin = (fduty == 16) ? erow % 8 : erow;
          pos = ((fduty == 16) ? erow / 8 : 0) * TCH + chr;
          bot = (fduty == 11) ? 10 : 7;
          b = fb(pos, rin)[CW-1-col];
          fbk = (pos == snap_cp) && snap_be && (((frm / BF) % 2) == 1);
          fc  = (pos == snap_cp) && snap_ce && (rin == bot);
          if (fbk && !b) by_blink = 1'b1;
          if (fc && !b) by_cur = 1'b1;
          b = b | fbk | fc;
          if (d < NSEG) eseg[d] = b; else eext[d-NSEG] = b;
        end
        chk(com_out == (16'(1) << erow), "R1 common select", int'(com_out), 1 << erow);
        chk(frame_start == (erow == 0), "R7 frame strobe", int'(frame_start), int'(erow == 0));
        if (!first)
          chk(gap == ((fduty == 16) ? RS : RL), "R2 row period", gap, (fduty == 16) ? RS : RL);
        chk(er == eext, "R4 extension dots", int'(er), int'(eext));
        if (alt_per_row || erow == 0) ealt = ~ealt;
        chk(alt_out == ealt, "R5 alternation", int'(alt_out), int'(ealt));
        ehold = eseg;
        tag = !disp_en ? "R6 blank" : by_blink ? "R9 blink" : by_cur ? "R8 cursor" : "R3 segments";
        chk(seg_out == (disp_en ? eseg : '0), tag, int'(seg_out), disp_en ? int'(eseg) : 0);
        gap = 0; first = 1'b0;
        if (erow == fduty - 1) begin
          erow = 0; frm++;
          fduty = two_line ? 16 : (tall_font ? 11 : 8);
        end else begin
          erow++;
        end
      end else begin
        chk(seg_out == (disp_en ? ehold : '0), "R6 hold/blank", int'(seg_out),
            disp_en ? int'(ehold) : 0);
      end
    end
  end

  task automatic wait_latch(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!ext_latch) @(negedge clk);
    end
    #1;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(com_out == '0 && seg_out == '0, "R10 reset outputs", int'(com_out), 0);
    chk(alt_out == 1'b0 && ext_latch == 1'b0 && frame_start == 1'b0,
        "R10 reset pulses", int'({alt_out, ext_latch, frame_start}), 0);
    #1 rst = 1'b0;
    wait_latch(19);                        // mid-frame mode change (R7)
    two_line = 1'b0; tall_font = 1'b0; cur_en = 1'b1; cur_pos = 3'd1;
    wait_latch(40);                        // tall font, cursor on row 10 (R8)
    tall_font = 1'b1; cur_pos = 3'd2; alt_per_row = 1'b0;
    wait_latch(40);                        // two lines, blink on second line (R9)
    two_line = 1'b1; cur_en = 1'b0; blink_en = 1'b1; cur_pos = 3'd4;
    wait_latch(80);
    wait_latch(5);                         // display off keeps the row (R6)
    disp_en = 1'b0;
    wait_latch(3);
    disp_en = 1'b1; blink_en = 1'b0; cur_en = 1'b1; cur_pos = 3'd5;
    wait_latch(20);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired at %0t", $time);
      finish_run();
    end
  end
endmodule